// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block decides which of three oscillators drives the system clock: an internal RC oscillator, an external crystal oscillator, or a PLL that can be fed from either. It runs in a single reference clock domain. The oscillators and the glitch-free clock multiplexer sit outside it. Each oscillator reports readiness on an asynchronous input, and the block drives an enable bit back to each one.

Software writes a requested source. The request is held in a pending register and takes effect only when the target is both enabled and reporting ready. A status field then reports the active source. Enable writes that would switch off a source the system clock depends on are refused, whether that dependence is direct or through the PLL.

When failure monitoring is armed, a failure of the external oscillator while it feeds the system clock has three effects. The system clock falls back to the internal oscillator, the external oscillator is switched off, and a sticky failure interrupt is raised.

Top module: `sysclk_switch_ctrl`

## Requirements
- R1: After reset, `act_code` is 0x0, `osc_en` is 3'b001 (bit 0 internal, bit 1 external, bit 2 PLL), and `pend_valid`, `fail_irq`, `mon_en` and `pll_src` are all 0.
- R2: A request for another source sets `pend_valid`. The switch happens on the first clock edge at which the target is enabled and its ready input has passed the two-flop synchroniser. A ready input rising between two edges therefore changes `act_code` after the third following edge. Until then the request stays pending.
- R3: `act_code` is a 4-bit field holding 0x0 for the internal oscillator, 0x4 for the external oscillator and 0x8 for the PLL. `sel_val` encodes 0 as internal, 1 as external and 2 as PLL.
- R4: A request naming the source that is already active changes nothing and clears any pending request.
- R5: A write to `osc_en` that would clear the bit of the active internal or external source leaves that bit set. The other bits of the write still take effect.
- R6: While the PLL is active, neither its own enable bit nor the enable bit of the oscillator feeding it can be cleared.
- R7: With `mon_en` set, an `ext_fail` pulse while the external oscillator feeds the system clock (directly, or via the PLL with `pll_src`=1) has four effects on the next edge: `act_code` becomes 0x0, external enable is cleared, internal enable is set, and `fail_irq` rises. It also drops any pending request.
- R8: `ext_fail` has no effect when `mon_en` is 0, or when the external oscillator does not feed the system clock.
- R9: `fail_irq` has no enable. It stays high until an `irq_clr` pulse.
- R10: An `osc_en` write whose external bit differs from the current external enable clears `mon_en`, and this takes priority over a `mon_we` in the same cycle. An `osc_en` write that leaves the external bit unchanged keeps `mon_en`.
- R11: A write to `pll_src` (0 selects internal, 1 selects external as PLL input) is ignored while the PLL is enabled.
- R12: A request with `sel_val` equal to 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| rdy_raw | input | 3 | Asynchronous ready flags (bit 0 internal, 1 external, 2 PLL) |
| ext_fail | input | 1 | External oscillator failure detect, synchronous pulse |
| sel_we | input | 1 | Source request write strobe |
| sel_val | input | 2 | Requested source |
| en_we | input | 1 | Oscillator enable write strobe |
| en_val | input | 3 | Requested enable bits |
| pllsrc_we | input | 1 | PLL input select write strobe |
| pllsrc_val | input | 1 | PLL input: 0 internal, 1 external |
| mon_we | input | 1 | Failure monitor enable write strobe |
| mon_val | input | 1 | Failure monitor enable value |
| irq_clr | input | 1 | Clears the failure interrupt |
| osc_en | output | 3 | Oscillator enable bits |
| act_code | output | 4 | Encoded active source |
| pend_valid | output | 1 | A source request is pending |
| pend_tgt | output | 2 | Pending target source |
| pll_src | output | 1 | Current PLL input select |
| mon_en | output | 1 | Failure monitor enable |
| fail_irq | output | 1 | Sticky failure interrupt |

## Verification
The hardest state to reach is a failure that arrives through the PLL. The PLL must be running from the external oscillator, and a protected disable write must already have been refused. The stimulus builds this up in order. It first selects the PLL input while the PLL is still off, then enables all sources, switches to the PLL, and attempts a blanket disable. It arms monitoring with an enable write that leaves the external bit alone, so the monitor stays set, and only then pulses the failure input. Exact switch timing is also checked by raising a ready input while a request waits, and sampling after each of the three edges that follow.

// File: rtl/sysclk_pkg.sv
package sysclk_pkg;
  localparam int NSRC   = 3;
  localparam int SEL_W  = $clog2(NSRC + 1);
  localparam int CODE_W = SEL_W + 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_INT = 2'd0,
    SRC_EXT = 2'd1,
    SRC_PLL = 2'd2
  } src_e;

  localparam int IDX_INT = 0;
  localparam int IDX_EXT = 1;
  localparam int IDX_PLL = 2;

  // Status encoding: source index shifted left by two.
  function automatic logic [CODE_W-1:0] src_code(src_e s);
    return {s, 2'b00};
  endfunction
endpackage

// File: rtl/clk_rdy_sync.sv
module clk_rdy_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] sh;
    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[STAGES-2:0], d[b]};
    end
    assign q[b] = sh[STAGES-1];
  end
endmodule

// File: rtl/clk_sel_core.sv
module clk_sel_core
  import sysclk_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic [NSRC-1:0]   rdy_s,
  input  logic [NSRC-1:0]   en_q,
  input  logic              fail_take,
  output src_e              active_q,
  output src_e              active_d,
  output logic              pend_valid,
  output src_e              pend_tgt,
  output logic [CODE_W-1:0] act_code
);
  logic pend_d;
  src_e tgt_d;
  logic switch_go;
  logic sel_legal;

  always_comb begin
    switch_go = pend_valid && rdy_s[pend_tgt] && en_q[pend_tgt];
    sel_legal = (sel_val != 2'd3);
    active_d  = active_q;
    if (fail_take)      active_d = SRC_INT;
    else if (switch_go) active_d = pend_tgt;

    pend_d = pend_valid;
    tgt_d  = pend_tgt;
    if (fail_take) begin
      pend_d = 1'b0;
    end else if (sel_we && sel_legal) begin
      if (src_e'(sel_val) == active_q) begin
        pend_d = 1'b0;
      end else begin
        pend_d = 1'b1;
        tgt_d  = src_e'(sel_val);
      end
    end else if (switch_go) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q   <= SRC_INT;
      pend_valid <= 1'b0;
      pend_tgt   <= SRC_INT;
      act_code   <= src_code(SRC_INT);
    end else begin
      active_q   <= active_d;
      pend_valid <= pend_d;
      pend_tgt   <= tgt_d;
      act_code   <= src_code(active_d);
    end
  end
endmodule

// File: rtl/clk_osc_ctrl.sv
module clk_osc_ctrl
  import sysclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            en_we,
  input  logic [NSRC-1:0] en_val,
  input  logic            pllsrc_we,
  input  logic            pllsrc_val,
  input  logic            mon_we,
  input  logic            mon_val,
  input  src_e            active_d,
  input  logic            fail_take,
  output logic [NSRC-1:0] en_q,
  output logic            pll_src_q,
  output logic            mon_en_q
);
  logic [NSRC-1:0] en_d;
  logic            int_busy, ext_busy, pll_busy;
  logic            pll_src_d, mon_d;

  always_comb begin
    pll_busy = (active_d == SRC_PLL);
    int_busy = (active_d == SRC_INT) || (pll_busy && !pll_src_q);
    ext_busy = (active_d == SRC_EXT) || (pll_busy && pll_src_q);

    en_d = en_q;
    if (en_we) begin
      en_d = en_val;
      if (int_busy) en_d[IDX_INT] = 1'b1;
      if (ext_busy) en_d[IDX_EXT] = 1'b1;
      if (pll_busy) en_d[IDX_PLL] = 1'b1;
    end
    if (fail_take) begin
      en_d[IDX_EXT] = 1'b0;
      en_d[IDX_INT] = 1'b1;
    end

    pll_src_d = pll_src_q;
    if (pllsrc_we && !en_q[IDX_PLL]) pll_src_d = pllsrc_val;

    mon_d = mon_en_q;
    if (mon_we) mon_d = mon_val;
    if (en_we && (en_val[IDX_EXT] != en_q[IDX_EXT])) mon_d = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q      <= NSRC'(1) << IDX_INT;
      pll_src_q <= 1'b0;
      mon_en_q  <= 1'b0;
    end else begin
      en_q      <= en_d;
      pll_src_q <= pll_src_d;
      mon_en_q  <= mon_d;
    end
  end
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon
  import sysclk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic ext_fail,
  input  logic mon_en,
  input  src_e active_q,
  input  logic pll_src,
  input  logic irq_clr,
  output logic fail_take,
  output logic fail_irq
);
  logic ext_feeds;

  always_comb begin
    ext_feeds = (active_q == SRC_EXT) || ((active_q == SRC_PLL) && pll_src);
    fail_take = mon_en && ext_fail && ext_feeds;
  end

  always_ff @(posedge clk) begin
    if (rst)            fail_irq <= 1'b0;
    else if (fail_take) fail_irq <= 1'b1;
    else if (irq_clr)   fail_irq <= 1'b0;
  end
endmodule

// File: rtl/sysclk_switch_ctrl.sv
module sysclk_switch_ctrl
  import sysclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NSRC-1:0]   rdy_raw,
  input  logic              ext_fail,
  input  logic              sel_we,
  input  logic [SEL_W-1:0]  sel_val,
  input  logic              en_we,
  input  logic [NSRC-1:0]   en_val,
  input  logic              pllsrc_we,
  input  logic              pllsrc_val,
  input  logic              mon_we,
  input  logic              mon_val,
  input  logic              irq_clr,
  output logic [NSRC-1:0]   osc_en,
  output logic [CODE_W-1:0] act_code,
  output logic              pend_valid,
  output logic [SEL_W-1:0]  pend_tgt,
  output logic              pll_src,
  output logic              mon_en,
  output logic              fail_irq
);
  logic [NSRC-1:0] rdy_s;
  src_e            active_q, active_d, tgt_e;
  logic            fail_take;

  clk_rdy_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(rdy_raw), .q(rdy_s)
  );

  clk_sel_core u_core (
    .clk(clk), .rst(rst), .sel_we(sel_we), .sel_val(sel_val),
    .rdy_s(rdy_s), .en_q(osc_en), .fail_take(fail_take),
    .active_q(active_q), .active_d(active_d),
    .pend_valid(pend_valid), .pend_tgt(tgt_e), .act_code(act_code)
  );

  clk_osc_ctrl u_osc (
    .clk(clk), .rst(rst), .en_we(en_we), .en_val(en_val),
    .pllsrc_we(pllsrc_we), .pllsrc_val(pllsrc_val),
    .mon_we(mon_we), .mon_val(mon_val),
    .active_d(active_d), .fail_take(fail_take),
    .en_q(osc_en), .pll_src_q(pll_src), .mon_en_q(mon_en)
  );

  clk_fail_mon u_fail (
    .clk(clk), .rst(rst), .ext_fail(ext_fail), .mon_en(mon_en),
    .active_q(active_q), .pll_src(pll_src), .irq_clr(irq_clr),
    .fail_take(fail_take), .fail_irq(fail_irq)
  );

  assign pend_tgt = tgt_e;
endmodule

// File: rtl/sysclk_switch_ctrl_chk.sv
module sysclk_switch_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       en_we,
  input logic [2:0] en_val,
  input logic       irq_clr,
  input logic [2:0] osc_en,
  input logic [3:0] act_code,
  input logic       pend_valid,
  input logic       pll_src,
  input logic       mon_en,
  input logic       fail_irq
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (act_code == 4'h0 && osc_en == 3'b001 && !pend_valid && !fail_irq));

  // R3
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == 4'h0 || act_code == 4'h4 || act_code == 4'h8));

  // R2
  switch_from_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (!$stable(act_code) && act_code != 4'h0) |-> $past(pend_valid));

  // R5
  int_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == 4'h0) |-> osc_en[0]);

  // R5
  ext_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == 4'h4) |-> osc_en[1]);

  // R6
  pll_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (act_code == 4'h8) |-> osc_en[2]);

  // R7
  fallback_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fail_irq) |-> (act_code == 4'h0 && !osc_en[1] && osc_en[0] && !pend_valid));

  // R9
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (fail_irq && !irq_clr) |=> fail_irq);

  // R10
  mon_cleared_chk: assert property (@(posedge clk) disable iff (rst)
    (en_we && (en_val[1] != osc_en[1])) |=> !mon_en);

  // R11
  pllsrc_locked_chk: assert property (@(posedge clk) disable iff (rst)
    $past(osc_en[2]) |-> $stable(pll_src));
endmodule

bind sysclk_switch_ctrl sysclk_switch_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .en_we(en_we), .en_val(en_val), .irq_clr(irq_clr),
  .osc_en(osc_en), .act_code(act_code), .pend_valid(pend_valid),
  .pll_src(pll_src), .mon_en(mon_en), .fail_irq(fail_irq)
);

// File: tb/test_sysclk_switch_ctrl.sv
`timescale 1ns/1ps
module test_sysclk_switch_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] rdy_raw = '0;
  logic       ext_fail = 1'b0;
  logic       sel_we = 1'b0;
  logic [1:0] sel_val = '0;
  logic       en_we = 1'b0;
  logic [2:0] en_val = '0;
  logic       pllsrc_we = 1'b0, pllsrc_val = 1'b0;
  logic       mon_we = 1'b0, mon_val = 1'b0;
  logic       irq_clr = 1'b0;
  logic [2:0] osc_en;
  logic [3:0] act_code;
  logic       pend_valid;
  logic [1:0] pend_tgt;
  logic       pll_src, mon_en, fail_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sysclk_switch_ctrl i_sysclk_switch_ctrl (
    .clk(clk), .rst(rst), .rdy_raw(rdy_raw), .ext_fail(ext_fail),
    .sel_we(sel_we), .sel_val(sel_val), .en_we(en_we), .en_val(en_val),
    .pllsrc_we(pllsrc_we), .pllsrc_val(pllsrc_val),
    .mon_we(mon_we), .mon_val(mon_val), .irq_clr(irq_clr),
    .osc_en(osc_en), .act_code(act_code), .pend_valid(pend_valid),
    .pend_tgt(pend_tgt), .pll_src(pll_src), .mon_en(mon_en), .fail_irq(fail_irq)
  );

  // fields: en[12:10] rdy[9:7] sel[6:5] code[4:1] pend[0]
  localparam logic [12:0] TBL [7] = '{
    {3'b011, 3'b011, 2'd1, 4'h4, 1'b0},
    {3'b011, 3'b001, 2'd1, 4'h0, 1'b1},
    {3'b101, 3'b101, 2'd2, 4'h8, 1'b0},
    {3'b101, 3'b001, 2'd2, 4'h0, 1'b1},
    {3'b001, 3'b011, 2'd1, 4'h0, 1'b1},
    {3'b111, 3'b111, 2'd0, 4'h0, 1'b0},
    {3'b111, 3'b111, 2'd3, 4'h0, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1; rdy_raw = '0; ext_fail = 1'b0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic wr_en(input logic [2:0] v);
    en_we = 1'b1; en_val = v; step(1); en_we = 1'b0;
  endtask

  task automatic wr_sel(input logic [1:0] v);
    sel_we = 1'b1; sel_val = v; step(1); sel_we = 1'b0;
  endtask

  task automatic wr_pllsrc(input logic v);
    pllsrc_we = 1'b1; pllsrc_val = v; step(1); pllsrc_we = 1'b0;
  endtask

  task automatic wr_mon(input logic v);
    mon_we = 1'b1; mon_val = v; step(1); mon_we = 1'b0;
  endtask

  task automatic pulse_fail();
    ext_fail = 1'b1; step(1); ext_fail = 1'b0;
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1; step(1); irq_clr = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(1);
    do_reset();
    // R1 reset state
    chk("R1 act_code", 8'(act_code), 8'h0);
    chk("R1 osc_en", 8'(osc_en), 8'h1);
    chk("R1 flags", {4'b0, pend_valid, fail_irq, mon_en, pll_src}, 8'h0);

    // R2 R3 R4 R12 table walk
    for (int i = 0; i < 7; i++) begin
      do_reset();
      rdy_raw = TBL[i][9:7];
      wr_en(TBL[i][12:10]);
      wr_sel(TBL[i][6:5]);
      step(3);
      chk($sformatf("R3 R2 row %0d code", i), 8'(act_code), 8'(TBL[i][4:1]));
      chk($sformatf("R2 R4 R12 row %0d pend", i), 8'(pend_valid), 8'(TBL[i][0]));
    end

    // R2 exact switch timing after ready rises
    do_reset();
    wr_en(3'b011);
    wr_sel(2'd1);
    step(2);
    chk("R2 held pend", 8'(pend_valid), 8'h1);
    chk("R2 held tgt", 8'(pend_tgt), 8'h1);
    rdy_raw = 3'b011;
    step(1);
    chk("R2 edge1 code", 8'(act_code), 8'h0);
    step(1);
    chk("R2 edge2 code", 8'(act_code), 8'h0);
    step(1);
    chk("R2 edge3 code", 8'(act_code), 8'h4);
    chk("R2 edge3 pend", 8'(pend_valid), 8'h0);

    // R5 active external cannot be disabled
    wr_en(3'b001);
    chk("R5 ext kept", 8'(osc_en), 8'h3);
    wr_en(3'b010);
    chk("R5 int off allowed", 8'(osc_en), 8'h2);
    chk("R5 code", 8'(act_code), 8'h4);

    // R6 R11 PLL fed from external
    do_reset();
    rdy_raw = 3'b111;
    wr_pllsrc(1'b1);
    chk("R11 src while off", 8'(pll_src), 8'h1);
    wr_en(3'b111);
    wr_sel(2'd2);
    step(2);
    chk("R6 pll active", 8'(act_code), 8'h8);
    wr_en(3'b000);
    chk("R6 en protected", 8'(osc_en), 8'h6);
    wr_pllsrc(1'b0);
    chk("R11 src locked", 8'(pll_src), 8'h1);

    // R10 write keeping external bit leaves monitor set
    wr_mon(1'b1);
    wr_en(3'b110);
    chk("R10 mon kept", 8'(mon_en), 8'h1);

    // R7 failure through PLL
    pulse_fail();
    chk("R7 code", 8'(act_code), 8'h0);
    chk("R7 osc_en", 8'(osc_en), 8'h5);
    chk("R7 irq", 8'(fail_irq), 8'h1);
    chk("R7 pend", 8'(pend_valid), 8'h0);
    step(5);
    chk("R9 irq held", 8'(fail_irq), 8'h1);
    pulse_clr();
    chk("R9 irq cleared", 8'(fail_irq), 8'h0);

    // R10 external reconfigure clears monitor, even with mon write
    wr_mon(1'b1);
    mon_we = 1'b1; mon_val = 1'b1;
    wr_en(3'b111);
    mon_we = 1'b0;
    chk("R10 mon cleared", 8'(mon_en), 8'h0);

    // R8 failure while external not feeding
    wr_mon(1'b1);
    pulse_fail();
    chk("R8 no irq int", 8'(fail_irq), 8'h0);
    chk("R8 en kept", 8'(osc_en), 8'h7);
    wr_sel(2'd1);
    step(1);
    chk("R8 on ext", 8'(act_code), 8'h4);
    wr_mon(1'b0);
    pulse_fail();
    chk("R8 mon off code", 8'(act_code), 8'h4);
    chk("R8 mon off irq", 8'(fail_irq), 8'h0);

    // R4 reselect active cancels pending
    rdy_raw = 3'b011;
    step(3);
    wr_sel(2'd2);
    chk("R4 pend set", 8'(pend_valid), 8'h1);
    wr_sel(2'd1);
    chk("R4 pend cleared", 8'(pend_valid), 8'h0);
    rdy_raw = 3'b111;
    step(4);
    chk("R4 stays ext", 8'(act_code), 8'h4);

    // R12 illegal select
    wr_sel(2'd3);
    step(2);
    chk("R12 ignored", {3'b0, pend_valid, act_code}, 8'h04);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule